// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits in front of instruction execution in a small processor core. Whenever it is idle it looks at the pending interrupt number and at the status register, then picks one of four outcomes. It can perform a reset. It can stack the program counter and the status word and then jump through a vector table. It can unstack a frame on a return request. Otherwise it grants the core one execute slot. The program counter, stack pointer and status register live outside the block. The block reads them as inputs and updates them through per-register write strobes.

Memory is reached through a simple port that moves one 16-bit word per access. The port has a request, a write enable, an address, write data, read data and a ready input. Every access lasts until ready is seen. An extended-address option widens the program counter and the stack pointer to 20 bits. In that mode the upper program-counter nibble travels in the top four bits of the stacked status word.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle. It makes no memory request and raises no register write strobe. It grants an execute slot when status bit 4 (CPU-off) is clear.
- R2: Request number 15 is taken whatever the interrupt enable is. The block reads the word at 0xFFFE. In the cycle that read completes it pulses the clear-all strobe and loads that word into the program counter, zero-extended.
- R3: Requests 0 to 13 are taken only when status bit 3 (global interrupt enable) is set. Requests 14 and 15 are always taken. A masked request causes no memory traffic and no register write.
- R4: A request number of 16 or more produces a one-cycle error pulse and nothing else.
- R5: Entry writes the low 16 bits of the program counter at SP-2 and then the status word at SP-4. The stack pointer is written with the new value in the same cycle as each of those memory writes.
- R6: With extended addressing the stacked status word is program-counter bits 19..16 in bits 15..12, followed by status bits 11..0.
- R7: Entry writes the status register with bits 3 and 4 cleared and all other bits unchanged. It then reads the word at 0xFFE0 + 2*n and loads it into the program counter.
- R8: In the cycle the vector is loaded, entry gives a one-cycle acknowledge carrying n and a completion pulse with cost 6.
- R9: When no interrupt is taken and no return is pending, status bit 4 set suppresses the execute grant.
- R10: A return request reads the word at SP into the status register, keeping only bits 11..0, and writes SP+2. It then reads the word at the new SP into the program counter and writes SP+4. It ends with a completion pulse of cost 5.
- R11: With extended addressing, bits 15..12 of the unstacked status word become program-counter bits 19..16 on return.
- R12: While ready is low, the request, address, write enable and write data stay constant. No register strobe fires until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | A request number is pending |
| irq_num | input | IRQ_W | Pending request number |
| reti_req | input | 1 | Core asks for a return-from-interrupt unstack |
| pc_i | input | PC_W | Current program counter |
| sp_i | input | PC_W | Current stack pointer |
| sr_i | input | 16 | Current status register |
| pc_we | output | 1 | Program-counter write strobe |
| pc_wd | output | PC_W | Program-counter write value |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wd | output | PC_W | Stack-pointer write value |
| sr_we | output | 1 | Status write strobe |
| sr_wd | output | 16 | Status write value |
| regs_clr | output | 1 | Clear every core register (reset request) |
| mem_req | output | 1 | Memory access active |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PC_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes this cycle |
| exec_grant | output | 1 | Core may execute one instruction this cycle |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_num | output | $clog2(NUM_LINES) | Number of the acknowledged request |
| irq_err | output | 1 | Out-of-range request number seen |
| seq_done | output | 1 | Entry or return finished |
| seq_cost | output | 4 | Cycle cost reported with seq_done |

## Verification
A request or return pulse is sampled at one rising edge. The first memory access is presented in the following cycle. Each later access starts one cycle after the previous one completes, and every result is due in the cycle its ready handshake completes. An entry with no wait states therefore produces its three handshakes in the three cycles after the sampling edge. A return produces its two handshakes in the two cycles after it. The bench queues the expected writes, acknowledge and completion in that order and compares them at the falling edge as they appear. Any stall inserted by the memory model delays the queue but never reorders it. Each sequence must drain the queue within a fixed window, and directed checks on the register mirror confirm the end state.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_RD,
      ST_PUSH_PC,
      ST_PUSH_SR,
      ST_VEC_RD,
      ST_POP_SR,
      ST_POP_PC
   } seq_state_e;

   localparam int unsigned COST_W     = 4;
   localparam int unsigned ENTRY_COST = 6;
   localparam int unsigned RET_COST   = 5;

   typedef struct packed {
      logic is_reset;
      logic take;
      logic bad;
   } irq_verdict_t;

endpackage

// File: rtl/irqseq_decide.sv
module irqseq_decide
   import irqseq_pkg::*;
#(
   parameter int IRQ_W     = 5,
   parameter int NUM_LINES = 16,
   parameter int NMI_MIN   = 14,
   parameter int RST_IRQ   = 15
) (
   input  logic             irq_valid,
   input  logic [IRQ_W-1:0] irq_num,
   input  logic             gie,
   output irq_verdict_t     verdict
);

   logic [31:0] num_wide;
   logic        in_range;
   logic        unmaskable;

   assign num_wide   = 32'(irq_num);
   assign in_range   = num_wide < 32'(NUM_LINES);
   assign unmaskable = num_wide >= 32'(NMI_MIN);

   always_comb begin
      verdict          = '0;
      verdict.bad      = irq_valid && !in_range;
      verdict.is_reset = irq_valid && in_range && (num_wide == 32'(RST_IRQ));
      verdict.take     = irq_valid && in_range && (num_wide != 32'(RST_IRQ))
                         && (gie || unmaskable);
   end

endmodule

// File: rtl/irqseq_addr.sv
module irqseq_addr #(
   parameter int          ADDR_W   = 20,
   parameter int          IDX_W    = 4,
   parameter logic [15:0] VEC_BASE = 16'hFFE0
) (
   input  logic [ADDR_W-1:0] sp,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] sp_dn,
   output logic [ADDR_W-1:0] sp_up,
   output logic [ADDR_W-1:0] vec_addr
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

   assign sp_dn    = sp - WORD_STEP;
   assign sp_up    = sp + WORD_STEP;
   assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'({idx, 1'b0});

endmodule

// File: rtl/irqseq_pack.sv
module irqseq_pack #(
   parameter bit EXT  = 1'b1,
   parameter int PC_W = 20
) (
   input  logic [PC_W-1:0] pc,
   input  logic [15:0]     sr,
   input  logic [3:0]      hi_nib,
   input  logic [15:0]     word,
   output logic [15:0]     stack_sr,
   output logic [PC_W-1:0] pc_restore
);

   generate
      if (EXT) begin : g_ext
         assign stack_sr   = {pc[PC_W-1:16], sr[11:0]};
         assign pc_restore = {hi_nib, word};
         logic unused_sr_top;
         assign unused_sr_top = &{1'b0, sr[15:12]};
      end else begin : g_base
         assign stack_sr   = sr;
         assign pc_restore = word;
         logic unused_base;
         assign unused_base = &{1'b0, hi_nib, pc};
      end
   endgenerate

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irqseq_pkg::*;
#(
   parameter bit          EXT_ADDR  = 1'b1,
   parameter int          IRQ_W     = 5,
   parameter int          NUM_LINES = 16,
   parameter int          NMI_MIN   = 14,
   parameter int          RST_IRQ   = 15,
   parameter int          GIE_BIT   = 3,
   parameter int          OFF_BIT   = 4,
   parameter logic [15:0] VEC_BASE  = 16'hFFE0,
   parameter logic [15:0] RST_VEC   = 16'hFFFE,
   localparam int         PC_W      = EXT_ADDR ? 20 : 16,
   localparam int         ACK_W     = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_valid,
   input  logic [IRQ_W-1:0]  irq_num,
   input  logic              reti_req,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [PC_W-1:0]   sp_i,
   input  logic [15:0]       sr_i,
   output logic              pc_we,
   output logic [PC_W-1:0]   pc_wd,
   output logic              sp_we,
   output logic [PC_W-1:0]   sp_wd,
   output logic              sr_we,
   output logic [15:0]       sr_wd,
   output logic              regs_clr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PC_W-1:0]   mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   input  logic              mem_ready,
   output logic              exec_grant,
   output logic              ack_valid,
   output logic [ACK_W-1:0]  ack_num,
   output logic              irq_err,
   output logic              seq_done,
   output logic [COST_W-1:0] seq_cost
);

   localparam logic [15:0] ENTRY_CLR = ~((16'd1 << GIE_BIT) | (16'd1 << OFF_BIT));
   localparam logic [15:0] KEEP_LOW  = 16'h0FFF;

   generate
      if (GIE_BIT == OFF_BIT || GIE_BIT > 15 || OFF_BIT > 15) begin : g_bad_bits
         $error("status bit positions must be distinct and below 16");
      end
      if (NUM_LINES > (1 << IRQ_W)) begin : g_bad_width
         $error("request number field too narrow for NUM_LINES");
      end
      if (RST_IRQ >= NUM_LINES || NMI_MIN > RST_IRQ) begin : g_bad_order
         $error("reset request must be in range and at or above the unmaskable floor");
      end
      if (VEC_BASE[0] || RST_VEC[0]) begin : g_bad_align
         $error("vector addresses must be word aligned");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [ACK_W-1:0] irq_q;
   logic [3:0]       hi_q;
   logic             cap_irq, cap_hi;

   irq_verdict_t     verdict;
   logic [PC_W-1:0]  sp_dn, sp_up, vec_addr;
   logic [15:0]      stack_sr;
   logic [PC_W-1:0]  pc_restore;

   irqseq_decide #(
      .IRQ_W     (IRQ_W),
      .NUM_LINES (NUM_LINES),
      .NMI_MIN   (NMI_MIN),
      .RST_IRQ   (RST_IRQ)
   ) u_decide (
      .irq_valid (irq_valid),
      .irq_num   (irq_num),
      .gie       (sr_i[GIE_BIT]),
      .verdict   (verdict)
   );

   irqseq_addr #(
      .ADDR_W   (PC_W),
      .IDX_W    (ACK_W),
      .VEC_BASE (VEC_BASE)
   ) u_addr (
      .sp       (sp_i),
      .idx      (irq_q),
      .sp_dn    (sp_dn),
      .sp_up    (sp_up),
      .vec_addr (vec_addr)
   );

   irqseq_pack #(
      .EXT  (EXT_ADDR),
      .PC_W (PC_W)
   ) u_pack (
      .pc         (pc_i),
      .sr         (sr_i),
      .hi_nib     (hi_q),
      .word       (mem_rdata),
      .stack_sr   (stack_sr),
      .pc_restore (pc_restore)
   );

   always_comb begin
      state_d    = state_q;
      pc_we      = 1'b0;
      pc_wd      = '0;
      sp_we      = 1'b0;
      sp_wd      = '0;
      sr_we      = 1'b0;
      sr_wd      = '0;
      regs_clr   = 1'b0;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      mem_wdata  = '0;
      exec_grant = 1'b0;
      ack_valid  = 1'b0;
      ack_num    = '0;
      irq_err    = 1'b0;
      seq_done   = 1'b0;
      seq_cost   = '0;
      cap_irq    = 1'b0;
      cap_hi     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (verdict.is_reset) begin
               state_d = ST_RST_RD;
            end else if (verdict.take) begin
               cap_irq = 1'b1;
               state_d = ST_PUSH_PC;
            end else if (verdict.bad) begin
               irq_err = 1'b1;
            end else if (reti_req) begin
               state_d = ST_POP_SR;
            end else if (!sr_i[OFF_BIT]) begin
               exec_grant = 1'b1;
            end
         end
         ST_RST_RD: begin
            mem_req  = 1'b1;
            mem_addr = PC_W'(RST_VEC);
            if (mem_ready) begin
               regs_clr = 1'b1;
               pc_we    = 1'b1;
               pc_wd    = PC_W'(mem_rdata);
               state_d  = ST_IDLE;
            end
         end
         ST_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dn;
            mem_wdata = pc_i[15:0];
            if (mem_ready) begin
               sp_we   = 1'b1;
               sp_wd   = sp_dn;
               state_d = ST_PUSH_SR;
            end
         end
         ST_PUSH_SR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dn;
            mem_wdata = stack_sr;
            if (mem_ready) begin
               sp_we   = 1'b1;
               sp_wd   = sp_dn;
               sr_we   = 1'b1;
               sr_wd   = sr_i & ENTRY_CLR;
               state_d = ST_VEC_RD;
            end
         end
         ST_VEC_RD: begin
            mem_req  = 1'b1;
            mem_addr = vec_addr;
            if (mem_ready) begin
               pc_we     = 1'b1;
               pc_wd     = PC_W'(mem_rdata);
               ack_valid = 1'b1;
               ack_num   = irq_q;
               seq_done  = 1'b1;
               seq_cost  = COST_W'(ENTRY_COST);
               state_d   = ST_IDLE;
            end
         end
         ST_POP_SR: begin
            mem_req  = 1'b1;
            mem_addr = sp_i;
            if (mem_ready) begin
               sr_we   = 1'b1;
               sr_wd   = mem_rdata & KEEP_LOW;
               sp_we   = 1'b1;
               sp_wd   = sp_up;
               cap_hi  = 1'b1;
               state_d = ST_POP_PC;
            end
         end
         ST_POP_PC: begin
            mem_req  = 1'b1;
            mem_addr = sp_i;
            if (mem_ready) begin
               pc_we    = 1'b1;
               pc_wd    = pc_restore;
               sp_we    = 1'b1;
               sp_wd    = sp_up;
               seq_done = 1'b1;
               seq_cost = COST_W'(RET_COST);
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         irq_q   <= '0;
         hi_q    <= '0;
      end else begin
         state_q <= state_d;
         if (cap_irq) irq_q <= irq_num[ACK_W-1:0];
         if (cap_hi)  hi_q  <= mem_rdata[15:12];
      end
   end

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R12
   write_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we || sp_we || sr_we || regs_clr) |-> mem_ready);

   // R5
   push_lands_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && mem_we) |-> (sp_wd == mem_addr));

   // R7
   entry_masks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (!sr_i[GIE_BIT] && !sr_i[OFF_BIT]));

   // R8
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !ack_valid);

   // R4
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (!mem_req && !exec_grant));

   // R9
   grant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_grant |-> (!sr_i[OFF_BIT] && !mem_req));

endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

   localparam int PC_W  = 20;
   localparam int IRQ_W = 5;

   localparam int K_MWR  = 0;
   localparam int K_SPW  = 1;
   localparam int K_SRW  = 2;
   localparam int K_PCW  = 3;
   localparam int K_CLR  = 4;
   localparam int K_ACK  = 5;
   localparam int K_ERR  = 6;
   localparam int K_DONE = 7;

   typedef struct {
      int          kind;
      logic [35:0] val;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_valid = 1'b0;
   logic [IRQ_W-1:0] irq_num = '0;
   logic reti_req = 1'b0;
   logic [PC_W-1:0] pc_r, sp_r;
   logic [15:0] sr_r;
   logic pc_we, sp_we, sr_we, regs_clr, mem_req, mem_we, mem_ready;
   logic [PC_W-1:0] pc_wd, sp_wd, mem_addr;
   logic [15:0] sr_wd, mem_wdata, mem_rdata;
   logic exec_grant, ack_valid, irq_err, seq_done;
   logic [3:0] ack_num, seq_cost;

   logic core_set = 1'b0;
   logic [PC_W-1:0] core_pc = '0, core_sp = '0;
   logic [15:0] core_sr = '0;
   logic poke_en = 1'b0;
   logic [PC_W-1:0] poke_addr = '0;
   logic [15:0] poke_data = '0;

   logic [15:0] bmem [512];
   int stall = 0;
   int wcnt = 0;

   exp_t expq[$];
   int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;

   always #4 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_num(irq_num),
      .reti_req(reti_req), .pc_i(pc_r), .sp_i(sp_r), .sr_i(sr_r),
      .pc_we(pc_we), .pc_wd(pc_wd), .sp_we(sp_we), .sp_wd(sp_wd),
      .sr_we(sr_we), .sr_wd(sr_wd), .regs_clr(regs_clr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .exec_grant(exec_grant), .ack_valid(ack_valid), .ack_num(ack_num),
      .irq_err(irq_err), .seq_done(seq_done), .seq_cost(seq_cost)
   );

   function automatic logic [8:0] widx(input logic [PC_W-1:0] a);
      return a[9:1];
   endfunction

   assign mem_rdata = bmem[widx(mem_addr)];
   assign mem_ready = (wcnt >= stall);

   always @(posedge clk) begin
      if (mem_req && !mem_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (poke_en) bmem[widx(poke_addr)] <= poke_data;
      else if (mem_req && mem_we && mem_ready) bmem[widx(mem_addr)] <= mem_wdata;
   end

   // register file owned by the core
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_r <= '0; sp_r <= '0; sr_r <= '0;
      end else if (core_set) begin
         pc_r <= core_pc; sp_r <= core_sp; sr_r <= core_sr;
      end else begin
         if (regs_clr) begin
            pc_r <= '0; sp_r <= '0; sr_r <= '0;
         end
         if (pc_we) pc_r <= pc_wd;
         if (sp_we) sp_r <= sp_wd;
         if (sr_we) sr_r <= sr_wd;
      end
   end

   task automatic mon_obs(input int k, input logic [35:0] v);
      exp_t e;
      mon_checks++;
      if (expq.size() == 0) begin
         mon_errors++;
         $display("FAIL R3/R4 unsolicited event kind %0d actual %h expected none", k, v);
      end else begin
         e = expq.pop_front();
         if (e.kind != k || e.val != v) begin
            mon_errors++;
            $display("FAIL %s kind %0d actual %h expected kind %0d value %h",
                     e.tag, k, v, e.kind, e.val);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_ready && mem_we) mon_obs(K_MWR, {mem_addr, mem_wdata});
         if (sp_we) mon_obs(K_SPW, 36'(sp_wd));
         if (sr_we) mon_obs(K_SRW, 36'(sr_wd));
         if (pc_we) mon_obs(K_PCW, 36'(pc_wd));
         if (regs_clr) mon_obs(K_CLR, 36'd0);
         if (ack_valid) mon_obs(K_ACK, 36'(ack_num));
         if (irq_err) mon_obs(K_ERR, 36'd0);
         if (seq_done) mon_obs(K_DONE, 36'(seq_cost));
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic push_exp(input int k, input logic [35:0] v, input string tag);
      exp_t e;
      e.kind = k; e.val = v; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic poke(input logic [PC_W-1:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      @(posedge clk); #1;
      poke_en = 1'b0;
   endtask

   task automatic set_regs(input logic [PC_W-1:0] p, input logic [PC_W-1:0] s, input logic [15:0] r);
      @(posedge clk); #1;
      core_set = 1'b1; core_pc = p; core_sp = s; core_sr = r;
      @(posedge clk); #1;
      core_set = 1'b0;
   endtask

   task automatic drain(input string tag);
      repeat (60) @(posedge clk);
      @(negedge clk);
      chk(expq.size() == 0, tag, 36'(expq.size()), 36'd0);
      expq.delete();
   endtask

   task automatic run_irq(input int n, input string tag);
      logic [PC_W-1:0] p, s;
      logic [15:0] r;
      p = pc_r; s = sp_r; r = sr_r;
      if (n >= 16) begin
         push_exp(K_ERR, 36'd0, tag);
      end else if (n == 15) begin
         push_exp(K_PCW, 36'(bmem[widx(20'h0FFFE)]), tag);
         push_exp(K_CLR, 36'd0, tag);
      end else if (r[3] || n >= 14) begin
         push_exp(K_MWR, {s - 20'd2, p[15:0]}, tag);
         push_exp(K_SPW, 36'(s - 20'd2), tag);
         push_exp(K_MWR, {s - 20'd4, p[19:16], r[11:0]}, tag);
         push_exp(K_SPW, 36'(s - 20'd4), tag);
         push_exp(K_SRW, 36'(r & 16'hFFE7), tag);
         push_exp(K_PCW, 36'(bmem[widx(20'h0FFE0 + 20'(2 * n))]), tag);
         push_exp(K_ACK, 36'(n), tag);
         push_exp(K_DONE, 36'd6, tag);
      end
      @(posedge clk); #1;
      irq_valid = 1'b1; irq_num = IRQ_W'(n);
      @(posedge clk); #1;
      irq_valid = 1'b0;
      drain(tag);
   endtask

   task automatic run_reti(input string tag);
      logic [PC_W-1:0] s;
      logic [15:0] w0, w1;
      s = sp_r;
      w0 = bmem[widx(s)];
      w1 = bmem[widx(s + 20'd2)];
      push_exp(K_SPW, 36'(s + 20'd2), tag);
      push_exp(K_SRW, 36'(w0 & 16'h0FFF), tag);
      push_exp(K_SPW, 36'(s + 20'd4), tag);
      push_exp(K_PCW, 36'({w0[15:12], w1}), tag);
      push_exp(K_DONE, 36'd5, tag);
      @(posedge clk); #1;
      reti_req = 1'b1;
      @(posedge clk); #1;
      reti_req = 1'b0;
      drain(tag);
   endtask

   task automatic run_tests;
      for (int n = 0; n < 16; n++) poke(20'h0FFE0 + 20'(2 * n), 16'hC100 + 16'(n * 16));
      poke(20'h0FFFE, 16'h8000);
      repeat (2) @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req, "R1 mem_req", 36'(mem_req), 36'd0);
      chk(!(pc_we || sp_we || sr_we || regs_clr), "R1 strobes", 36'({pc_we, sp_we, sr_we, regs_clr}), 36'd0);
      chk(exec_grant, "R1 grant", 36'(exec_grant), 36'd1);

      // R5 R6 R7 R8 enabled entry
      set_regs(20'h12344, 20'h00280, 16'h0008);
      run_irq(3, "R5_R6_R7_R8 entry irq3");
      chk(pc_r == 20'h0C130, "R7 vector pc", 36'(pc_r), 36'h0C130);
      chk(sp_r == 20'h0027C, "R5 sp after entry", 36'(sp_r), 36'h0027C);

      // R10 R11 return of that frame
      run_reti("R10_R11 return");
      chk(pc_r == 20'h12344, "R11 pc restored", 36'(pc_r), 36'h12344);
      chk(sr_r == 16'h0008, "R10 sr restored", 36'(sr_r), 36'h0008);
      chk(sp_r == 20'h00280, "R10 sp restored", 36'(sp_r), 36'h00280);

      // R3 masked request ignored
      set_regs(20'h05000, 20'h00280, 16'h0000);
      run_irq(5, "R3 masked irq5");
      chk(sp_r == 20'h00280 && pc_r == 20'h05000, "R3 masked regs", 36'({pc_r[15:0], sp_r[15:0]}), 36'h50000280);

      // R9 CPU-off suppresses grant
      set_regs(20'h05000, 20'h00280, 16'h0010);
      repeat (3) begin
         @(negedge clk);
         chk(!exec_grant, "R9 off no grant", 36'(exec_grant), 36'd0);
      end

      // R3 R12 unmaskable 14 with stalls, from CPU-off
      stall = 2;
      run_irq(14, "R3_R12 nmi14 stalled");
      chk(sr_r == 16'h0000, "R7 off cleared", 36'(sr_r), 36'd0);
      @(negedge clk);
      chk(exec_grant, "R9 grant after wake", 36'(exec_grant), 36'd1);

      // R6 R7 busy status word
      stall = 0;
      set_regs(20'h9ABCE, 20'h002C0, 16'hA51C);
      run_irq(7, "R6_R7 entry irq7");
      chk(sr_r == 16'hA504, "R7 status masked", 36'(sr_r), 36'hA504);

      // R4 out-of-range request
      run_irq(20, "R4 bad irq20");
      chk(sp_r == 20'h002BC, "R4 sp untouched", 36'(sp_r), 36'h002BC);

      // R10 R11 R12 crafted frame with stall
      poke(20'h00300, 16'hF3FF);
      poke(20'h00302, 16'h4321);
      set_regs(20'h01000, 20'h00300, 16'h0000);
      stall = 1;
      run_reti("R10_R11_R12 crafted return");
      chk(pc_r == 20'hF4321, "R11 upper nibble", 36'(pc_r), 36'hF4321);
      chk(sr_r == 16'h03FF, "R10 low 12 bits", 36'(sr_r), 36'h03FF);

      // R2 reset request with interrupts disabled
      stall = 3;
      set_regs(20'h01000, 20'h00300, 16'h0000);
      run_irq(15, "R2 reset irq15");
      chk(pc_r == 20'h08000, "R2 pc", 36'(pc_r), 36'h08000);
      chk(sp_r == 20'h0 && sr_r == 16'h0, "R2 cleared", 36'({sp_r, sr_r}), 36'd0);

      // R8 highest maskable with stall
      set_regs(20'h04000, 20'h00290, 16'h0008);
      run_irq(13, "R8 entry irq13 stalled");
      chk(pc_r == 20'h0C1D0, "R8 pc irq13", 36'(pc_r), 36'h0C1D0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
      $finish;
   end

endmodule